// File: doc/BRIEF.md
# I2C Target Status and Interrupt Register Block

This block is the status and interrupt section of an I2C target controller. The serial engine sends it single-cycle event pulses: a byte transmission starts, a byte reception completes, a bus-free request arrives, the output data does not match, an asynchronous address is detected, a NAK is received, or a STOP condition is seen. Each event sets a sticky flag in a 16-bit status register, and software clears a flag by writing 1 to its bit. A read-only summary bit is set while any flag is set. That bit, gated by an enable, drives the interrupt line.

The block also holds the transmit and receive byte registers and the control bits: module enable, communication mode, clock stretching and interrupt enable. It keeps a "transmit loaded" marker and a "receive full" marker. When clock stretching is off, these markers let it detect a transmit underflow or a receive overflow, which share one flag bit. The transfer direction selects which of the two the bit reports. When the engine reports an address match, the block tells it whether to acknowledge. It acknowledges only when both the module enable bit and the communication-mode bit are set. Otherwise the master sees a NAK.

The register interface is a plain address, write strobe, read strobe and combinational read-data bus. The bit-level shifter and the pads sit outside this block.

Top module: `i2c_tgt_status`

## Requirements
- R1: After a synchronous active-low reset, all flags, control bits and markers are 0, and `irq` and `ack_addr` are low.
- R2: The status register (offset 1) reads {8'h00, summary, 1'b0, flags[5:0]}. Bits 15 to 8 and bit 6 always read 0.
- R3: Each event pulse sets its flag, and the flag stays set until it is cleared: `ev_stop` sets bit 0, `ev_nak` bit 1, `ev_async_addr` bit 2, `ev_mismatch` bit 3, `ev_bus_free` bit 4.
- R4: Writing the status register clears each flag whose write-data bit is 1 and leaves flags whose bit is 0 unchanged. An event in the same cycle as a clear of the same flag leaves the flag set.
- R5: Status bit 7 reads 1 while any of bits 5 to 0 is 1 and 0 once all are 0. Writing bit 7 has no effect.
- R6: `irq` is high exactly when the summary bit is 1 and the interrupt enable (control bit 3) is 1.
- R7: With direction transmit (`dir_tx`=1) and clock stretching off, a `ev_tx_start` pulse sets bit 5 if no transmit byte was written since the previous start. Writing the transmit register (offset 2) before the start prevents it.
- R8: With direction receive (`dir_tx`=0) and clock stretching off, an `ev_rx_done` pulse sets bit 5 if the previous received byte has not been read from the receive register (offset 3). A read strobe at offset 3 marks the byte as read.
- R9: With clock stretching on (control bit 2), neither underflow nor overflow sets bit 5.
- R10: `ack_addr` is high exactly when `addr_match` is high, module enable (control bit 1) is 1 and communication mode (control bit 0) is 1.
- R11: The control register (offset 0) reads back bits 3 to 0. The transmit register reads back the last written byte. The receive register returns the last byte delivered with `ev_rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (consumes the receive byte at offset 3) |
| rd_data | output | 16 | Read data for `addr` |
| dir_tx | input | 1 | Transfer direction, 1 = transmit |
| ev_tx_start | input | 1 | Byte transmission start pulse |
| ev_rx_done | input | 1 | Byte reception complete pulse |
| rx_byte | input | BW | Received byte, valid with `ev_rx_done` |
| ev_bus_free | input | 1 | Bus-free request pulse |
| ev_mismatch | input | 1 | Output data mismatch pulse |
| ev_async_addr | input | 1 | Asynchronous address detect pulse |
| ev_nak | input | 1 | NAK received pulse |
| ev_stop | input | 1 | STOP condition pulse |
| addr_match | input | 1 | Engine saw this target's address |
| ack_addr | output | 1 | Acknowledge the address |
| tx_byte | output | BW | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 2-bit address with the four registers at offsets 0 to 3, and 8-bit data bytes. These defaults make every register reachable and let a full byte pattern travel through both data registers. Within that setup the bench drives each event alone and together with a same-cycle clear. It runs the underflow and overflow paths with the data register accessed and not accessed, with stretching on and off. It also walks all four combinations of the enable and communication-mode gates on the acknowledge.

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status #(
  parameter int AW = 2,
  parameter int BW = 8,
  parameter logic [AW-1:0] OFF_CTRL = 0,
  parameter logic [AW-1:0] OFF_STAT = 1,
  parameter logic [AW-1:0] OFF_TXD  = 2,
  parameter logic [AW-1:0] OFF_RXD  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  input  logic          dir_tx,
  input  logic          ev_tx_start,
  input  logic          ev_rx_done,
  input  logic [BW-1:0] rx_byte,
  input  logic          ev_bus_free,
  input  logic          ev_mismatch,
  input  logic          ev_async_addr,
  input  logic          ev_nak,
  input  logic          ev_stop,
  input  logic          addr_match,
  output logic          ack_addr,
  output logic [BW-1:0] tx_byte,
  output logic          irq
);
  localparam int NFLG = 6;

  logic [NFLG-1:0] flg;
  logic            comm, en, strch, ien;
  logic [BW-1:0]   txd, rxd;
  logic            tx_ld, rx_full;

  wire sel_ctrl = addr == OFF_CTRL;
  wire sel_stat = addr == OFF_STAT;
  wire sel_txd  = addr == OFF_TXD;
  wire sel_rxd  = addr == OFF_RXD;

  wire uf = ev_tx_start & dir_tx & ~tx_ld & ~strch;
  wire ov = ev_rx_done & ~dir_tx & rx_full & ~strch;

  wire [NFLG-1:0] set_v = {uf | ov, ev_bus_free, ev_mismatch,
                           ev_async_addr, ev_nak, ev_stop};
  wire [NFLG-1:0] clr_v = (wr_en & sel_stat) ? wr_data[NFLG-1:0] : '0;

  wire summary = |flg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg     <= '0;
      comm    <= 1'b0;
      en      <= 1'b0;
      strch   <= 1'b0;
      ien     <= 1'b0;
      txd     <= '0;
      rxd     <= '0;
      tx_ld   <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      flg <= (flg & ~clr_v) | set_v;
      if (wr_en & sel_ctrl) begin
        comm  <= wr_data[0];
        en    <= wr_data[1];
        strch <= wr_data[2];
        ien   <= wr_data[3];
      end
      if (wr_en & sel_txd) txd <= wr_data[BW-1:0];
      if (wr_en & sel_txd)  tx_ld <= 1'b1;
      else if (ev_tx_start) tx_ld <= 1'b0;
      if (ev_rx_done) begin
        rxd     <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_en & sel_rxd) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_ctrl)     rd_data[3:0] = {ien, strch, en, comm};
    else if (sel_stat) rd_data[7:0] = {summary, 1'b0, flg};
    else if (sel_txd)  rd_data[BW-1:0] = txd;
    else if (sel_rxd)  rd_data[BW-1:0] = rxd;
  end

  assign irq      = summary & ien;
  assign ack_addr = addr_match & en & comm;
  assign tx_byte  = txd;
endmodule

// File: rtl/i2c_tgt_status_chk.sv
module i2c_tgt_status_chk #(
  parameter int AW = 2,
  parameter logic [AW-1:0] OFF_CTRL = 0,
  parameter logic [AW-1:0] OFF_STAT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic [15:0]   rd_data,
  input logic          dir_tx,
  input logic          ev_rx_done,
  input logic          ev_stop,
  input logic          ack_addr,
  input logic          irq,
  input logic [5:0]    flg,
  input logic          rx_full,
  input logic          strch
);
  wire [5:0] keep = (wr_en && addr == OFF_STAT) ? ~wr_data[5:0] : 6'h3f;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg & $past(flg & keep)) == $past(flg & keep))); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> flg[0]); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr == OFF_STAT |-> (rd_data[15:8] == 8'h00 && !rd_data[6])); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg != 6'h00)); // R6
  AST_ACK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTRL && !wr_data[0]) |=> !ack_addr); // R10
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && rx_full && !strch && !dir_tx) |=> flg[5]); // R8
endmodule

bind i2c_tgt_status i2c_tgt_status_chk #(.AW(AW), .OFF_CTRL(OFF_CTRL), .OFF_STAT(OFF_STAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .dir_tx(dir_tx), .ev_rx_done(ev_rx_done), .ev_stop(ev_stop),
  .ack_addr(ack_addr), .irq(irq), .flg(flg), .rx_full(rx_full), .strch(strch)
);

// File: tb/i2c_tgt_status_bench.sv
`timescale 1ns/1ps
module i2c_tgt_status_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  addr = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        dir_tx = 0, ev_tx_start = 0, ev_rx_done = 0;
  logic [7:0]  rx_byte = 0;
  logic        ev_bus_free = 0, ev_mismatch = 0, ev_async_addr = 0, ev_nak = 0, ev_stop = 0;
  logic        addr_match = 0;
  logic        ack_addr, irq;
  logic [7:0]  tx_byte;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_tgt_status u_i2c_tgt_status (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dir_tx(dir_tx), .ev_tx_start(ev_tx_start),
    .ev_rx_done(ev_rx_done), .rx_byte(rx_byte), .ev_bus_free(ev_bus_free),
    .ev_mismatch(ev_mismatch), .ev_async_addr(ev_async_addr), .ev_nak(ev_nak),
    .ev_stop(ev_stop), .addr_match(addr_match), .ack_addr(ack_addr),
    .tx_byte(tx_byte), .irq(irq)
  );

  localparam logic [1:0] A_CTRL = 0, A_STAT = 1, A_TXD = 2, A_RXD = 3;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit strobe, output logic [15:0] d);
    addr = a; rd_en = strobe;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic pulse(input int idx);
    case (idx)
      0: ev_stop = 1;
      1: ev_nak = 1;
      2: ev_async_addr = 1;
      3: ev_mismatch = 1;
      4: ev_bus_free = 1;
      default: ;
    endcase
    @(negedge clk);
    {ev_stop, ev_nak, ev_async_addr, ev_mismatch, ev_bus_free} = '0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_byte = b; ev_rx_done = 1;
    @(negedge clk);
    ev_rx_done = 0;
  endtask

  task automatic tx_start();
    ev_tx_start = 1;
    @(negedge clk);
    ev_tx_start = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    addr_match = 1;
    #1;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 ack", {15'b0, ack_addr}, 16'h0);
    rd(A_STAT, 0, d); chk("R1 stat", d, 16'h0000);
    rd(A_CTRL, 0, d); chk("R1 ctrl", d, 16'h0000);
    addr_match = 0;
  endtask

  task automatic t_events();
    logic [15:0] d;
    for (int i = 0; i < 5; i++) begin
      pulse(i);
      rd(A_STAT, 0, d); chk("R3 set", d, 16'h0080 | (16'h1 << i));
      pulse(5);
      rd(A_STAT, 0, d); chk("R3 sticky", d, 16'h0080 | (16'h1 << i));
      wr(A_STAT, 16'h1 << i);
      rd(A_STAT, 0, d); chk("R4 clear", d, 16'h0000);
    end
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    pulse(0); pulse(1);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 0, d); chk("R4 write0", d, 16'h0083);
    wr(A_STAT, 16'hff40);
    rd(A_STAT, 0, d); chk("R2 R5 reserved/bit7 write", d, 16'h0083);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, 0, d); chk("R5 partial", d, 16'h0082);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, 0, d); chk("R5 summary drops", d, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    ev_stop = 1;
    wr(A_STAT, 16'h0001);
    ev_stop = 0;
    rd(A_STAT, 0, d); chk("R4 set wins", d, 16'h0081);
    wr(A_STAT, 16'h003f);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(A_CTRL, 16'h0008);
    chk("R6 idle", {15'b0, irq}, 16'h0);
    pulse(1);
    chk("R6 raised", {15'b0, irq}, 16'h1);
    wr(A_STAT, 16'h0002);
    chk("R6 cleared", {15'b0, irq}, 16'h0);
    wr(A_CTRL, 16'h0000);
    pulse(1);
    chk("R6 disabled", {15'b0, irq}, 16'h0);
    rd(A_STAT, 0, d); chk("R6 flag still", d, 16'h0082);
    wr(A_STAT, 16'h0002);
  endtask

  task automatic t_underflow();
    logic [15:0] d;
    dir_tx = 1;
    tx_start();
    rd(A_STAT, 0, d); chk("R7 underflow", d, 16'h00a0);
    wr(A_STAT, 16'h0020);
    wr(A_TXD, 16'h005a);
    chk("R11 tx_byte", {8'h0, tx_byte}, 16'h005a);
    tx_start();
    rd(A_STAT, 0, d); chk("R7 loaded", d, 16'h0000);
    rd(A_TXD, 0, d); chk("R11 txd", d, 16'h005a);
    tx_start();
    rd(A_STAT, 0, d); chk("R7 consumed", d, 16'h00a0);
    wr(A_STAT, 16'h0020);
  endtask

  task automatic t_overflow();
    logic [15:0] d;
    dir_tx = 0;
    rx(8'h11);
    rd(A_STAT, 0, d); chk("R8 first", d, 16'h0000);
    rx(8'h22);
    rd(A_STAT, 0, d); chk("R8 overflow", d, 16'h00a0);
    rd(A_RXD, 1, d); chk("R11 rxd", d, 16'h0022);
    wr(A_STAT, 16'h0020);
    rx(8'hc3);
    rd(A_STAT, 0, d); chk("R8 read in time", d, 16'h0000);
    rd(A_RXD, 1, d); chk("R11 rxd2", d, 16'h00c3);
  endtask

  task automatic t_stretch();
    logic [15:0] d;
    wr(A_CTRL, 16'h0004);
    dir_tx = 1;
    tx_start();
    rd(A_STAT, 0, d); chk("R9 no underflow", d, 16'h0000);
    dir_tx = 0;
    rx(8'h01); rx(8'h02);
    rd(A_STAT, 0, d); chk("R9 no overflow", d, 16'h0000);
    rd(A_RXD, 1, d);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_ack();
    logic [15:0] d;
    addr_match = 1;
    for (int c = 0; c < 4; c++) begin
      wr(A_CTRL, 16'(c));
      chk("R10 gate", {15'b0, ack_addr}, (c == 3) ? 16'h1 : 16'h0);
    end
    rd(A_CTRL, 0, d); chk("R11 ctrl", d, 16'h0003);
    addr_match = 0;
    #1 chk("R10 no match", {15'b0, ack_addr}, 16'h0);
    wr(A_CTRL, 16'h000f);
    rd(A_CTRL, 0, d); chk("R11 ctrl all", d, 16'h000f);
    wr(A_CTRL, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_w1c();
    t_set_wins();
    t_irq();
    t_underflow();
    t_overflow();
    t_stretch();
    t_ack();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule